// File: doc/BRIEF.md
# Incrementing-Pattern Stream Checker

This block sits on the output of a device under test and decides whether a 64-bit AXI4-Stream passed through it unchanged. Before each packet a controller arms it with the number of beats the packet should carry. The checker then accepts beats and compares each one against a running count. The count starts at zero for every packet and goes up by one for each accepted beat. On each beat it also checks that tlast is high on the final beat and on no earlier beat.

While armed, the checker holds tready high. It waits through any cycles in which the source has no valid data. After the final beat it drops tready, raises a one-cycle done pulse and presents a fail flag. The fail flag collects every data or framing mismatch seen in that packet. It keeps its value until the next packet is armed.

Top module: `pattern_stream_checker`

## Requirements
- R1: After reset, s_tready, done and fail are all 0.
- R2: A start pulse while idle with a nonzero len_beats arms the checker: s_tready is 1 from the next cycle and fail reads 0 from the next cycle.
- R3: The accepted beat number n (counting from 1) must carry data equal to n-1, zero-extended to 64 bits. Any other value sets fail.
- R4: tlast high on any accepted beat before beat len_beats sets fail.
- R5: tlast low on accepted beat len_beats sets fail.
- R6: Cycles with s_tvalid low are waited through. They are not counted as beats, and they neither end the packet nor raise done.
- R7: In the cycle after beat len_beats is accepted, s_tready is 0 and done is 1 for exactly one cycle. fail holds the packet's final result in that cycle.
- R8: Within a packet, fail stays set once set. After done it holds its value until the next arm.
- R9: A len_beats of 1 is legal. The single beat must carry data 0 with tlast high.
- R10: start is ignored while a packet is in progress, and the length already in use is kept. A start with len_beats equal to 0 is ignored while idle, and s_tready stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Arm request for one packet check |
| len_beats | input | LEN_W (16) | Expected packet length in beats, sampled on arm |
| s_tdata | input | DATA_W (64) | Stream data |
| s_tvalid | input | 1 | Stream valid |
| s_tlast | input | 1 | Stream last-beat marker |
| s_tready | output | 1 | Stream ready, high while a packet is being checked |
| done | output | 1 | One-cycle pulse after the final beat |
| fail | output | 1 | Result of the last checked packet, sticky within it |

## Verification
Clean packets of several lengths, some with idle gaps between beats, show that correct traffic never raises fail and that gaps are not counted as beats. Packets with a corrupted first, middle or final data word test the count comparison at both ends of the packet. Packets with a tlast that comes early or goes missing test the framing check apart from the data check. Single-beat packets, start pulses sent mid-packet and start pulses with a zero length cover the arming edge cases. A failing packet followed by a clean one shows that fail holds after a failure and clears on the next arm.

// File: rtl/pattern_chk_pkg.sv
// Package: shared types for the incrementing-pattern stream checker.
// Assumes: nothing; pure type definitions.
package pattern_chk_pkg;
    typedef enum logic [0:0] {
        CHK_IDLE = 1'b0,
        CHK_RUN  = 1'b1
    } chk_state_e;
endpackage

// File: rtl/pattern_chk_ctrl.sv
// Module: packet control for the stream checker. Accepts an arm request,
// holds the expected length, counts accepted beats, flags the final beat,
// drops ready after it and pulses done.
// Assumes: beat is valid & ready as formed by the parent.
module pattern_chk_ctrl
    import pattern_chk_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] len_in,
    input  logic             beat,
    output logic             ready,
    output logic             arm,
    output logic             is_last,
    output logic             done
);
    localparam int CMP_W = LEN_W + 1;

    chk_state_e       state_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] idx_q;

    // Arm only from idle with a usable length.
    assign arm     = (state_q == CHK_IDLE) && start && (len_in != '0);
    // Ready follows the run state.
    assign ready   = (state_q == CHK_RUN);
    // The beat about to be accepted is the final one.
    assign is_last = (CMP_W'(idx_q) + CMP_W'(1)) == CMP_W'(len_q);

    // State, length capture, beat counter and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CHK_IDLE;
            len_q   <= '0;
            idx_q   <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state_q)
                CHK_IDLE: begin
                    if (arm) begin
                        len_q   <= len_in;
                        idx_q   <= '0;
                        state_q <= CHK_RUN;
                    end
                end
                CHK_RUN: begin
                    if (beat) begin
                        idx_q <= idx_q + LEN_W'(1);
                        if (is_last) begin
                            state_q <= CHK_IDLE;
                            done    <= 1'b1;
                        end
                    end
                end
                default: state_q <= CHK_IDLE;
            endcase
        end
    end

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7
    done_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !ready);
    // R6
    idle_gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !beat) |=> $stable(idx_q));
    // R10
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && start && !(beat && is_last)) |=> (ready && $stable(len_q)));
endmodule

// File: rtl/pattern_chk_cmp.sv
// Module: compare stage. Keeps the expected running count and folds every
// data or tlast mismatch into a fail flag that is sticky within a packet.
// Assumes: arm and beat never coincide (ready is low while arming).
module pattern_chk_cmp #(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              beat,
    input  logic              is_last,
    input  logic [DATA_W-1:0] data,
    input  logic              last,
    output logic              fail
);
    logic [DATA_W-1:0] exp_q;
    logic              data_bad;
    logic              frame_bad;

    // Data mismatch against the running count.
    assign data_bad  = (data != exp_q);
    // tlast must match the final-beat position exactly.
    assign frame_bad = (last != is_last);

    // Expected count and sticky fail flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_q <= '0;
            fail  <= 1'b0;
        end else if (arm) begin
            exp_q <= '0;
            fail  <= 1'b0;
        end else if (beat) begin
            exp_q <= exp_q + DATA_W'(1);
            if (data_bad || frame_bad) fail <= 1'b1;
        end
    end

    // R2
    arm_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> !fail);
    // R8
    fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !arm) |=> fail);
    // R3
    data_err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && (data != exp_q)) |=> fail);
    // R4
    early_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && last && !is_last) |=> fail);
endmodule

// File: rtl/pattern_stream_checker.sv
// Module: top of the incrementing-pattern stream checker. Joins the
// control and compare stages on one AXI4-Stream slave port.
// Assumes: start is a controller request; len_beats sampled on arm.
module pattern_stream_checker #(
    parameter int DATA_W = 64,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  len_beats,
    input  logic [DATA_W-1:0] s_tdata,
    input  logic              s_tvalid,
    input  logic              s_tlast,
    output logic              s_tready,
    output logic              done,
    output logic              fail
);
    logic ready;
    logic arm;
    logic is_last;
    logic beat;

    // A beat is a handshake on the slave port.
    assign beat     = s_tvalid && ready;
    assign s_tready = ready;

    pattern_chk_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .len_in  (len_beats),
        .beat    (beat),
        .ready   (ready),
        .arm     (arm),
        .is_last (is_last),
        .done    (done)
    );

    pattern_chk_cmp #(.DATA_W(DATA_W)) u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (arm),
        .beat    (beat),
        .is_last (is_last),
        .data    (s_tdata),
        .last    (s_tlast),
        .fail    (fail)
    );

    // R5
    missing_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && is_last && !s_tlast) |=> (fail && done));
endmodule

// File: tb/pattern_stream_checker_bench.sv
module pattern_stream_checker_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 64;
    localparam int LW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [LW-1:0] len_beats = '0;
    logic [DW-1:0] s_tdata = '0;
    logic          s_tvalid = 1'b0;
    logic          s_tlast = 1'b0;
    logic          s_tready, done, fail;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pattern_stream_checker #(.DATA_W(DW), .LEN_W(LW)) u_pattern_stream_checker (
        .clk(clk), .rst_n(rst_n), .start(start), .len_beats(len_beats),
        .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tlast(s_tlast),
        .s_tready(s_tready), .done(done), .fail(fail)
    );

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL watchdog: act=%0d exp<=20000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // Vector: {len[7:0], kind[7:0], pos[7:0], gap[3:0], exp_fail[3:0]}
    // kind 0 clean, 1 data corrupt at pos, 2 early tlast at pos, 3 no tlast at end
    localparam int NV = 9;
    localparam logic [31:0] VEC [NV] = '{
        {8'd4, 8'd0, 8'd0, 4'd0, 4'd0},
        {8'd5, 8'd0, 8'd0, 4'd2, 4'd0},
        {8'd4, 8'd1, 8'd2, 4'd0, 4'd1},
        {8'd6, 8'd2, 8'd3, 4'd1, 4'd1},
        {8'd3, 8'd3, 8'd0, 4'd0, 4'd1},
        {8'd1, 8'd0, 8'd0, 4'd0, 4'd0},
        {8'd1, 8'd3, 8'd0, 4'd0, 4'd1},
        {8'd8, 8'd1, 8'd8, 4'd0, 4'd1},
        {8'd8, 8'd1, 8'd1, 4'd3, 4'd1}
    };

    // Arm one packet and check the arm outcome (R2).
    task automatic arm_pkt(input int len);
        @(negedge clk);
        start = 1'b1; len_beats = LW'(len);
        @(negedge clk);
        start = 1'b0;
        check("R2 ready after arm", 64'(s_tready), 64'd1);
        check("R2 fail cleared", 64'(fail), 64'd0);
    endtask

    // Drive len beats; ends at the negedge after the final handshake.
    task automatic drive_beats(input int len, input int kind, input int pos, input int gap);
        for (int b = 1; b <= len; b++) begin
            for (int g = 0; g < gap; g++) begin
                s_tvalid = 1'b0;
                @(negedge clk);
                check("R6 no done during gap", 64'(done), 64'd0);
                check("R6 ready during gap", 64'(s_tready), 64'd1);
            end
            s_tvalid = 1'b1;
            s_tdata  = 64'(b - 1);
            if (kind == 1 && b == pos) s_tdata = s_tdata ^ 64'h100;
            s_tlast  = (b == len);
            if (kind == 2 && b == pos) s_tlast = 1'b1;
            if (kind == 3 && b == len) s_tlast = 1'b0;
            @(negedge clk);
            if (b < len) check("R6 no early done", 64'(done), 64'd0);
        end
        s_tvalid = 1'b0; s_tlast = 1'b0;
    endtask

    // Check the end-of-packet outcome, then the following idle cycle.
    task automatic check_end(input string tag, input int exp_fail);
        check({tag, " R7 done"}, 64'(done), 64'd1);
        check({tag, " R7 ready low"}, 64'(s_tready), 64'd0);
        check({tag, " fail"}, 64'(fail), 64'(exp_fail));
        @(negedge clk);
        check({tag, " R7 done one cycle"}, 64'(done), 64'd0);
        check({tag, " R8 fail held"}, 64'(fail), 64'(exp_fail));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 ready reset", 64'(s_tready), 64'd0);
        check("R1 done reset", 64'(done), 64'd0);
        check("R1 fail reset", 64'(fail), 64'd0);
        rst_n = 1'b1;

        // Table walk: R3 R4 R5 R6 R9
        for (int i = 0; i < NV; i++) begin
            automatic int len  = int'(VEC[i][31:24]);
            automatic int kind = int'(VEC[i][23:16]);
            automatic int pos  = int'(VEC[i][15:8]);
            automatic int gap  = int'(VEC[i][7:4]);
            automatic int expf = int'(VEC[i][3:0]);
            arm_pkt(len);
            drive_beats(len, kind, pos, gap);
            check_end($sformatf("vec%0d R3/R4/R5/R9", i), expf);
        end

        // R8: a failing packet, fail held over idle cycles, cleared by next arm
        arm_pkt(2);
        drive_beats(2, 1, 1, 0);
        check_end("R8 failing pkt", 1);
        repeat (3) @(negedge clk);
        check("R8 fail held idle", 64'(fail), 64'd1);
        arm_pkt(2);
        drive_beats(2, 0, 0, 0);
        check_end("R8 clean after fail", 0);

        // R10: start mid-packet is ignored, original length kept
        arm_pkt(3);
        s_tvalid = 1'b1; s_tdata = 64'd0; s_tlast = 1'b0;
        start = 1'b1; len_beats = LW'(1);
        @(negedge clk);
        start = 1'b0;
        check("R10 no done after busy start", 64'(done), 64'd0);
        check("R10 still ready", 64'(s_tready), 64'd1);
        s_tdata = 64'd1;
        @(negedge clk);
        s_tdata = 64'd2; s_tlast = 1'b1;
        @(negedge clk);
        s_tvalid = 1'b0; s_tlast = 1'b0;
        check_end("R10 busy start", 0);

        // R10: zero length start ignored
        @(negedge clk);
        start = 1'b1; len_beats = '0;
        @(negedge clk);
        start = 1'b0;
        check("R10 zero len no ready", 64'(s_tready), 64'd0);
        check("R10 zero len no done", 64'(done), 64'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule